// File: doc/BRIEF.md
# One-Shot Pulse Generator

This block is a non-retriggerable monostable. A trigger input, which may be narrower than one clock period, starts one output pulse whose length is a fixed number of clock cycles set by a parameter. The default length gives one second at 50 MHz. Simulation overrides the parameter with a small value.

A flip-flop with an asynchronous set catches the trigger. Its output passes through a synchronizer into a counter running on the system clock. When the count completes, the counter raises a stop strobe for one cycle. The strobe clears the capture flop, so the block re-arms. Triggers that arrive while a pulse is running are absorbed, because the capture flop is already set. After the stop, the counter waits for the synchronizer to flush before it looks for a new capture.

If the trigger is still high when the stop arrives, the asynchronous set wins and the capture flop stays set. A held trigger therefore yields a train of full-length pulses with a fixed gap between them.

Top module: `oneshot_pulse`

## Requirements
- R1: While the active-low asynchronous reset is low, the output is low at once and the capture flop is held clear. A trigger that arrives and ends while reset is low produces no pulse after release.
- R2: A trigger high for less than one clock period, between clock edges, is captured and produces a pulse.
- R3: The output rises at the (SYNC_STAGES+1)-th rising clock edge after the trigger rises. With SYNC_STAGES=2 this is the third edge.
- R4: Each pulse stays high for exactly PULSE_CYCLES clock cycles.
- R5: A trigger arriving while a pulse is high neither restarts nor extends that pulse, and produces no later pulse if it ends before the pulse ends.
- R6: At the end of a pulse, a one-cycle stop strobe clears the capture flop. The strobe is never high together with the output. A trigger arriving after the block has re-armed starts a new pulse with the latency of R3.
- R7: A trigger held high beyond the end of a pulse produces back-to-back full-length pulses separated by exactly SYNC_STAGES+2 low cycles. No further pulse follows once the trigger is low before the current pulse ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low, priority over the trigger |
| trig_i | input | 1 | Trigger, any width, asynchronous to the clock |
| pulse_o | output | 1 | Registered output pulse, PULSE_CYCLES cycles long |

## Verification
The output is due at the third rising edge after the trigger, with two synchronizer stages plus the counter register. It then stays high for PULSE_CYCLES edges. After a held trigger, it comes back after a gap of SYNC_STAGES+2 cycles. The bench samples `pulse_o` on falling clock edges, counting falling edges from the trigger to measure latency, high time and gap, and compares each count against these figures. An asynchronous reset is checked a fraction of a cycle after it is applied, before any clock edge. Ignored triggers are checked by watching the output stay low for many cycles after the event.

// File: rtl/oneshot_pulse.sv
module oneshot_pulse #(
  parameter int PULSE_CYCLES = 50_000_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);

  localparam int CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam int FW = $clog2(SYNC_STAGES + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYCLES - 1);
  localparam logic [FW-1:0] FLUSH_END = FW'(SYNC_STAGES);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLUSH} state_t;

  state_t                 state_q;
  logic                   cap_q;
  logic                   stop_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic [FW-1:0]          fcnt_q;
  logic                   active_q;
  logic                   cap_s;

  // capture: async clear by reset, async set by trigger, sync clear by stop
  always_ff @(posedge clk or posedge trig_i or negedge rst_n) begin
    if (!rst_n)      cap_q <= 1'b0;
    else if (trig_i) cap_q <= 1'b1;
    else             cap_q <= cap_q & ~stop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], cap_q};
  end

  assign cap_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      fcnt_q   <= '0;
      active_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      stop_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cap_s) begin
          state_q  <= ST_RUN;
          cnt_q    <= '0;
          active_q <= 1'b1;
        end
        ST_RUN: if (cnt_q == LAST) begin
          state_q  <= ST_FLUSH;
          active_q <= 1'b0;
          stop_q   <= 1'b1;
          fcnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ST_FLUSH: if (fcnt_q == FLUSH_END) state_q <= ST_IDLE;
                  else                     fcnt_q  <= fcnt_q + 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pulse_o = active_q;

endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
  parameter int PULSE_CYCLES = 50_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic pulse_o,
  input logic stop
);

  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (pulse_o) run_len <= run_len + 1;
    else              run_len <= '0;
  end

  assert_stop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !stop);

  assert_stop_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !pulse_o);

  assert_stop_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> stop);

  assert_len_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> (run_len == 32'(PULSE_CYCLES)));

  assert_no_extend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (run_len < 32'(PULSE_CYCLES)));

endmodule

bind oneshot_pulse oneshot_pulse_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_o(pulse_o), .stop(stop_q)
);

// File: tb/oneshot_pulse_test.sv
`timescale 1ns/1ps
module oneshot_pulse_test;

  localparam int P    = 20;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;
  localparam int GAP  = SYNC + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic pulse;

  int checks = 0;
  int fails  = 0;

  oneshot_pulse #(.PULSE_CYCLES(P), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .pulse_o(pulse)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fire_short();
    @(negedge clk);
    #2 trig = 1'b1;
    #1 trig = 1'b0;
  endtask

  task automatic wait_rise(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!pulse && lat < 500);
  endtask

  task automatic count_high(output int n);
    n = 1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (pulse) n++;
      else break;
    end
  endtask

  task automatic low_for(input int cyc, output int highs);
    highs = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pulse) highs++;
    end
  endtask

  task automatic t_reset();
    int h;
    #1 check(pulse == 1'b0, "R1 output low in reset", pulse, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    low_for(10, h);
    check(h == 0, "R1 idle after reset", h, 0);
  endtask

  task automatic t_short();
    int lat, n;
    fire_short();
    wait_rise(lat);
    check(lat == LAT, "R2/R3 sub-cycle trigger latency", lat, LAT);
    count_high(n);
    check(n == P, "R4 pulse length", n, P);
    low_for(30, n);
    check(n == 0, "R4 single pulse only", n, 0);
  endtask

  task automatic t_mid();
    int lat, n, h;
    fire_short();
    wait_rise(lat);
    check(lat == LAT, "R3 latency before mid trigger", lat, LAT);
    n = 1;
    for (int i = 0; i < 500; i++) begin
      if (n == 6) begin
        #2 trig = 1'b1;
        #1 trig = 1'b0;
      end
      @(negedge clk);
      if (pulse) n++;
      else break;
    end
    check(n == P, "R5 mid-pulse trigger no extend", n, P);
    low_for(40, h);
    check(h == 0, "R5 mid-pulse trigger ignored", h, 0);
  endtask

  task automatic t_long();
    int lat, n1, n2, gap, h;
    @(negedge clk);
    #2 trig = 1'b1;
    wait_rise(lat);
    check(lat == LAT, "R7 held trigger latency", lat, LAT);
    count_high(n1);
    check(n1 == P, "R7 first pulse length", n1, P);
    gap = 1;
    for (int i = 0; i < 500 && !pulse; i++) begin
      @(negedge clk);
      if (!pulse) gap++;
    end
    check(gap == GAP, "R7 gap between pulses", gap, GAP);
    #2 trig = 1'b0;
    count_high(n2);
    check(n2 == P, "R7 second pulse length", n2, P);
    low_for(40, h);
    check(h == 0, "R7 no pulse after release", h, 0);
  endtask

  task automatic t_async_reset();
    int lat, h;
    fire_short();
    wait_rise(lat);
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check(pulse == 1'b0, "R1 async reset clears output", pulse, 0);
    #2 trig = 1'b1;
    #1 trig = 1'b0;
    repeat (2) @(negedge clk);
    #2 rst_n = 1'b1;
    low_for(40, h);
    check(h == 0, "R1 trigger in reset ignored", h, 0);
  endtask

  task automatic t_rearm();
    int lat, n;
    fire_short();
    wait_rise(lat);
    check(lat == LAT, "R6 re-armed trigger latency", lat, LAT);
    count_high(n);
    check(n == P, "R6 re-armed pulse length", n, P);
  endtask

  initial begin
    t_reset();
    t_short();
    t_mid();
    t_long();
    t_async_reset();
    t_rearm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule